// File: doc/BRIEF.md
# HMAC-SHA-256 Stage Sequencer

This block drives an external SHA-256 compression engine through the full keyed-hash message authentication flow. The engine takes a one-cycle `eng_start` together with a 512-bit block and a 256-bit chaining value. Some cycles later it answers with a one-cycle `eng_done` and the resulting 256-bit chaining value. The sequencer prepares the block-sized key, XORs it with the inner and outer pad patterns, and feeds key blocks and pre-padded text blocks from a valid/ready stream. It then builds the final outer block itself and returns the complete 256-bit MAC.

At most five hashing phases run, always in the same order: long-key reduction, inner key block, text, outer key block, final outer block. The key length and a reuse flag decide which phases run. The chaining values after the inner key block and after the outer key block are cached. A later MAC with the same key can therefore skip every key phase. The register that caches the outer chaining value also holds the running digest while a long key is being reduced.

Top module: `hmac_seq`

## Requirements
- R1: After reset `busy`, `mac_valid`, `blk_ready` and `eng_start` are all 0.
- R2: For a key no longer than the block (`long_key`=0), byte i of `key_data` (byte 0 = bits 511:504) is kept when i < `key_len` and replaced by zero otherwise; `key_len`=0 gives an all-zero key.
- R3: With `key_len`=64 the 512-bit `key_data` is used unchanged as the padded key.
- R4: With `long_key`=1 the key blocks taken from the stream are hashed starting from the SHA-256 initial value (6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19). The last block is the one flagged by `blk_last`. The resulting digest followed by 256 zero bits is the padded key K0.
- R5: The MAC is H(opad block, final block), where H chains from the initial value. The opad block is K0 XOR 0x5C in every byte. The final block is the inner digest, then byte 0x80, then zeros, then the 64-bit length 768 in its low bits. The inner digest chains from H(initial value, K0 XOR 0x36 in every byte) over all text blocks.
- R6: Without reuse, a MAC issues exactly (key blocks) + 2 + (text blocks) + 1 engine starts, in phase order. `eng_start` is never high in two consecutive cycles.
- R7: Text blocks are taken one per hash until and including the block flagged by `blk_last`, each chaining from the previous result.
- R8: With `reuse_key`=1 the key phases are skipped. The text hash starts from the cached inner key chaining value and the final hash from the cached outer one, so a MAC issues exactly (text blocks) + 1 starts and equals the MAC with the last prepared key.
- R9: `busy` rises the cycle after an accepted `start` and stays high until `mac_valid` rises; `mac_valid` is never high while `busy`. A `start` while `busy` is ignored.
- R10: `mac_valid` clears the cycle after an accepted `start`. Once set, `mac_valid` and the full 256-bit `mac` hold until the next accepted `start`.
- R11: `blk_ready` is high only while a key or text block is awaited and no hash is outstanding; a block offered at any other time is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a MAC computation (when idle) |
| reuse_key | input | 1 | Use the cached key chaining values |
| long_key | input | 1 | Key arrives as blocks on the stream and must be reduced |
| key_len | input | 7 | Length in bytes of a short key |
| key_data | input | 512 | Short key, byte 0 in the top bits |
| blk_valid | input | 1 | Stream block offered |
| blk_last | input | 1 | Offered block is the last of its phase |
| blk_data | input | 512 | Stream block (pre-padded) |
| blk_ready | output | 1 | Stream block accepted this cycle when valid |
| eng_start | output | 1 | Start one compression |
| eng_block | output | 512 | Block for the compression |
| eng_cv | output | 256 | Chaining value loaded into the engine |
| eng_done | input | 1 | Compression finished |
| eng_digest | input | 256 | Chaining value produced by the engine |
| busy | output | 1 | A MAC computation is in progress |
| mac_valid | output | 1 | `mac` holds a finished result |
| mac | output | 256 | Full-width MAC |

## Verification
A table of cases runs the flow with a full 64-byte key, short keys of 0, 20 and 33 bytes with non-zero data in the dropped bytes, and long keys of one and three blocks. Reuse runs with one and two text blocks follow, and text streams range from one to four blocks. MAC comparison separates correct masking, pad bytes and final-block layout, while the count of engine starts separates which phases ran, so a skipped or repeated phase shows even where a MAC might coincide. Directed cases offer a stray block during the key phase and pulse `start` with reuse mid-run, and each time check that nothing is consumed or restarted.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;
  localparam int BLK_W  = 512;
  localparam int CV_W   = 256;
  localparam int BYTES  = BLK_W / 8;
  localparam int LEN_W  = $clog2(BYTES) + 1;
  localparam int TAIL_Z = BLK_W - CV_W - 8 - 64;

  localparam logic [CV_W-1:0] SHA_IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [7:0]  IPAD_BYTE  = 8'h36;
  localparam logic [7:0]  OPAD_BYTE  = 8'h5c;
  localparam logic [63:0] OUTER_BITS = 64'(BLK_W + CV_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEWKEY, ST_KIPAD, ST_TEXT, ST_KOPAD, ST_MAC
  } stage_e;
endpackage

// File: rtl/hmac_key_mask.sv
module hmac_key_mask
  import hmac_seq_pkg::*;
#(
  parameter int W  = BLK_W,
  parameter int LW = LEN_W
) (
  input  logic [W-1:0]  key_i,
  input  logic [LW-1:0] len_i,
  output logic [W-1:0]  k0_o
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign k0_o[W-1-8*b -: 8] = (len_i > LW'(b)) ? key_i[W-1-8*b -: 8] : 8'h00;
  end
endmodule

// File: rtl/hmac_pad_xor.sv
module hmac_pad_xor
  import hmac_seq_pkg::*;
#(
  parameter int         W   = BLK_W,
  parameter logic [7:0] PAD = IPAD_BYTE
) (
  input  logic [W-1:0] k0_i,
  output logic [W-1:0] blk_o
);
  assign blk_o = k0_i ^ {(W/8){PAD}};
endmodule

// File: rtl/hmac_outer_tail.sv
module hmac_outer_tail
  import hmac_seq_pkg::*;
#(
  parameter int W  = BLK_W,
  parameter int CW = CV_W
) (
  input  logic [CW-1:0] dig_i,
  output logic [W-1:0]  blk_o
);
  localparam int ZW = W - CW - 8 - 64;

  assign blk_o = {dig_i, 8'h80, {ZW{1'b0}}, OUTER_BITS};
endmodule

// File: rtl/hmac_seq.sv
module hmac_seq
  import hmac_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               reuse_key,
  input  logic               long_key,
  input  logic [LEN_W-1:0]   key_len,
  input  logic [BLK_W-1:0]   key_data,
  input  logic               blk_valid,
  input  logic               blk_last,
  input  logic [BLK_W-1:0]   blk_data,
  output logic               blk_ready,
  output logic               eng_start,
  output logic [BLK_W-1:0]   eng_block,
  output logic [CV_W-1:0]    eng_cv,
  input  logic               eng_done,
  input  logic [CV_W-1:0]    eng_digest,
  output logic               busy,
  output logic               mac_valid,
  output logic [CV_W-1:0]    mac
);
  stage_e st_q, st_d;
  logic wait_q, wait_d, last_q, last_d, reuse_q, reuse_d;
  logic klong_q, klong_d, valid_q, valid_d;

  logic [BLK_W-1:0] k0_q, k0_masked, k0_cur, ipad_blk, opad_blk, tail_blk;
  logic [CV_W-1:0]  ipad_q, inner_q, opad_q, mac_q;
  logic [CV_W-1:0]  inner_nx, opad_nx;
  logic k0_en, ipad_en, inner_en, opad_en, mac_en;
  logic done_ok;

  hmac_key_mask #(.W(BLK_W), .LW(LEN_W)) i_mask (
    .key_i(key_data), .len_i(key_len), .k0_o(k0_masked));

  // long key: reduced digest lives in the outer-state register
  assign k0_cur = klong_q ? {opad_q, {(BLK_W-CV_W){1'b0}}} : k0_q;

  hmac_pad_xor #(.W(BLK_W), .PAD(IPAD_BYTE)) i_ipad (.k0_i(k0_cur), .blk_o(ipad_blk));
  hmac_pad_xor #(.W(BLK_W), .PAD(OPAD_BYTE)) i_opad (.k0_i(k0_cur), .blk_o(opad_blk));
  hmac_outer_tail #(.W(BLK_W), .CW(CV_W)) i_tail (.dig_i(inner_q), .blk_o(tail_blk));

  assign done_ok = wait_q && eng_done;

  // next-state logic
  always_comb begin
    st_d      = st_q;
    wait_d    = wait_q;
    last_d    = last_q;
    reuse_d   = reuse_q;
    klong_d   = klong_q;
    valid_d   = valid_q;
    k0_en     = 1'b0;
    ipad_en   = 1'b0;
    inner_en  = 1'b0;
    opad_en   = 1'b0;
    mac_en    = 1'b0;
    inner_nx  = eng_digest;
    opad_nx   = eng_digest;
    eng_start = 1'b0;
    blk_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          valid_d = 1'b0;
          wait_d  = 1'b0;
          reuse_d = reuse_key;
          if (reuse_key) begin
            st_d     = ST_TEXT;
            inner_en = 1'b1;
            inner_nx = ipad_q;
          end else if (long_key) begin
            st_d    = ST_NEWKEY;
            klong_d = 1'b1;
            opad_en = 1'b1;
            opad_nx = SHA_IV;
          end else begin
            st_d    = ST_KIPAD;
            klong_d = 1'b0;
            k0_en   = 1'b1;
          end
        end
      end
      ST_NEWKEY, ST_TEXT: begin
        blk_ready = !wait_q;
        if (!wait_q && blk_valid) begin
          eng_start = 1'b1;
          wait_d    = 1'b1;
          last_d    = blk_last;
        end
        if (done_ok) begin
          wait_d = 1'b0;
          if (st_q == ST_NEWKEY) begin
            opad_en = 1'b1;
            if (last_q) st_d = ST_KIPAD;
          end else begin
            inner_en = 1'b1;
            if (last_q) st_d = reuse_q ? ST_MAC : ST_KOPAD;
          end
        end
      end
      ST_KIPAD, ST_KOPAD, ST_MAC: begin
        if (!wait_q) begin
          eng_start = 1'b1;
          wait_d    = 1'b1;
        end else if (eng_done) begin
          wait_d = 1'b0;
          if (st_q == ST_KIPAD) begin
            ipad_en  = 1'b1;
            inner_en = 1'b1;
            st_d     = ST_TEXT;
          end else if (st_q == ST_KOPAD) begin
            opad_en = 1'b1;
            st_d    = ST_MAC;
          end else begin
            mac_en  = 1'b1;
            valid_d = 1'b1;
            st_d    = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // engine operand select
  always_comb begin
    eng_block = blk_data;
    eng_cv    = SHA_IV;
    unique case (st_q)
      ST_NEWKEY: begin eng_block = blk_data; eng_cv = opad_q;  end
      ST_KIPAD:  begin eng_block = ipad_blk; eng_cv = SHA_IV;  end
      ST_TEXT:   begin eng_block = blk_data; eng_cv = inner_q; end
      ST_KOPAD:  begin eng_block = opad_blk; eng_cv = SHA_IV;  end
      ST_MAC:    begin eng_block = tail_blk; eng_cv = opad_q;  end
      default:   begin eng_block = blk_data; eng_cv = SHA_IV;  end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wait_q  <= 1'b0;
      last_q  <= 1'b0;
      reuse_q <= 1'b0;
      klong_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      last_q  <= last_d;
      reuse_q <= reuse_d;
      klong_q <= klong_d;
      valid_q <= valid_d;
    end
  end

  // datapath registers, enabled loads only
  always_ff @(posedge clk) begin
    if (k0_en)    k0_q    <= k0_masked;
    if (ipad_en)  ipad_q  <= eng_digest;
    if (inner_en) inner_q <= inner_nx;
    if (opad_en)  opad_q  <= opad_nx;
    if (mac_en)   mac_q   <= eng_digest;
  end

  assign busy      = (st_q != ST_IDLE);
  assign mac_valid = valid_q;
  assign mac       = mac_q;
endmodule

// File: rtl/hmac_seq_chk.sv
module hmac_seq_chk
  import hmac_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            mac_valid,
  input logic [CV_W-1:0] mac,
  input logic            eng_start,
  input logic            blk_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!blk_ready && !eng_start)); // R11

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R9

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |-> !busy); // R9

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !mac_valid); // R10

  AST_MAC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !start) |=> (mac_valid && $stable(mac))); // R10

  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6
endmodule

bind hmac_seq hmac_seq_chk i_hmac_seq_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .mac_valid(mac_valid), .mac(mac), .eng_start(eng_start), .blk_ready(blk_ready));

// File: tb/test_hmac_seq.sv
module test_hmac_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, reuse_key = 1'b0, long_key = 1'b0;
  logic [6:0]   key_len = '0;
  logic [511:0] key_data = '0;
  logic         blk_valid = 1'b0, blk_last = 1'b0;
  logic [511:0] blk_data = '0;
  logic         blk_ready, eng_start, busy, mac_valid;
  logic [511:0] eng_block;
  logic [255:0] eng_cv, mac;
  logic         eng_done = 1'b0;
  logic [255:0] eng_digest = '0;

  int checks = 0, fails = 0, cyc = 0;
  int n_starts = 0, stub_cnt = 0, stub_dly = 2;
  logic [255:0] stub_hold = '0;
  logic [511:0] saved_k0 = '0;

  localparam logic [255:0] IV0 = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  // {key_len, key blocks, text blocks, flags: bit0 reuse, bit1 long}
  localparam logic [31:0] VEC [8] = '{
    {8'd64, 8'd0, 8'd1, 8'h0},   // R3
    {8'd20, 8'd0, 8'd1, 8'h0},   // R2
    {8'd0,  8'd0, 8'd2, 8'h0},   // R2
    {8'd0,  8'd1, 8'd1, 8'h2},   // R4
    {8'd0,  8'd3, 8'd3, 8'h2},   // R4 R7
    {8'd0,  8'd0, 8'd2, 8'h1},   // R8
    {8'd0,  8'd0, 8'd1, 8'h1},   // R8
    {8'd33, 8'd0, 8'd4, 8'h0}    // R7
  };

  hmac_seq i_hmac_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reuse_key(reuse_key),
    .long_key(long_key), .key_len(key_len), .key_data(key_data),
    .blk_valid(blk_valid), .blk_last(blk_last), .blk_data(blk_data),
    .blk_ready(blk_ready), .eng_start(eng_start), .eng_block(eng_block),
    .eng_cv(eng_cv), .eng_done(eng_done), .eng_digest(eng_digest),
    .busy(busy), .mac_valid(mac_valid), .mac(mac));

  always #10 clk = ~clk;

  function automatic logic [255:0] cmp(input logic [255:0] cv, input logic [511:0] blk);
    logic [255:0] acc = cv;
    for (int i = 0; i < 16; i++) begin
      acc = {acc[242:0], acc[255:243]} ^ {8{blk[511-32*i -: 32]}};
      acc = acc + {224'd0, 32'(i + 1) * 32'h01000193};
    end
    return acc;
  endfunction

  function automatic logic [511:0] gen(input int seed, input int idx);
    logic [511:0] r;
    for (int i = 0; i < 16; i++)
      r[511-32*i -: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(idx) * 32'h85EBCA6B)
                          ^ (32'(i) * 32'hC2B2AE35) ^ 32'h5A5A0F0F;
    return r;
  endfunction

  // behavioural compression engine
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      n_starts  <= n_starts + 1;
      stub_hold <= cmp(eng_cv, eng_block);
      stub_cnt  <= stub_dly;
    end else if (stub_cnt > 1) begin
      stub_cnt <= stub_cnt - 1;
    end else if (stub_cnt == 1) begin
      stub_cnt   <= 0;
      eng_done   <= 1'b1;
      eng_digest <= stub_hold;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic feed(input logic [511:0] d, input logic last);
    int guard = 0;
    blk_valid = 1'b1; blk_data = d; blk_last = last;
    while (!blk_ready && guard < 2000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  // mode 0 plain, 1 start pulsed while busy, 2 stray block during key phase
  task automatic run_case(input int klen, input int nkey, input int ntext,
                          input int flags, input int seed, input int mode);
    logic [511:0] k0, kd;
    logic [255:0] acc, ocv, exp_mac, held;
    int base, exp_starts, guard;
    logic reuse = flags[0];
    logic lng = flags[1];
    kd = gen(seed, 300);
    if (reuse) k0 = saved_k0;
    else if (lng) begin
      acc = IV0;
      for (int j = 0; j < nkey; j++) acc = cmp(acc, gen(seed, 200 + j));
      k0 = {acc, 256'd0};
    end else begin
      for (int b = 0; b < 64; b++)
        k0[511-8*b -: 8] = (b < klen) ? kd[511-8*b -: 8] : 8'h00;
    end
    saved_k0 = k0;
    acc = cmp(IV0, k0 ^ {64{8'h36}});
    for (int j = 0; j < ntext; j++) acc = cmp(acc, gen(seed, 100 + j));
    ocv = cmp(IV0, k0 ^ {64{8'h5c}});
    exp_mac = cmp(ocv, {acc, 8'h80, 184'd0, 64'd768});
    exp_starts = (reuse ? 0 : (lng ? nkey : 0) + 2) + ntext + 1;

    @(negedge clk);
    base = n_starts;
    start = 1'b1; reuse_key = reuse; long_key = lng;
    key_len = 7'(klen); key_data = kd;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", 256'(busy), 256'd1);
    chk(mac_valid === 1'b0, "R10 valid cleared by start", 256'(mac_valid), 256'd0);
    if (mode == 1) begin
      start = 1'b1; reuse_key = 1'b1; long_key = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (mode == 2) begin
      blk_valid = 1'b1; blk_data = '1; blk_last = 1'b1;
      for (int s = 0; s < 2; s++) begin
        chk(blk_ready === 1'b0, "R11 no ready in key phase", 256'(blk_ready), 256'd0);
        @(negedge clk);
      end
      blk_valid = 1'b0; blk_last = 1'b0;
    end
    if (lng && !reuse)
      for (int j = 0; j < nkey; j++) feed(gen(seed, 200 + j), j == nkey - 1);
    for (int j = 0; j < ntext; j++) feed(gen(seed, 100 + j), j == ntext - 1);
    guard = 0;
    while (!mac_valid && guard < 2000) begin
      @(negedge clk); guard++;
    end
    chk(mac === exp_mac, "R5 R7 mac value", mac, exp_mac);
    chk((n_starts - base) == exp_starts,
        reuse ? "R8 start count" : (lng ? "R4 R6 start count" : "R6 start count"),
        256'(n_starts - base), 256'(exp_starts));
    held = mac;
    repeat (3) @(negedge clk);
    chk(mac_valid === 1'b1 && mac === held, "R10 mac held", mac, held);
    chk(busy === 1'b0, "R9 idle after mac", 256'(busy), 256'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R1 busy reset", 256'(busy), 256'd0);
    chk(mac_valid === 1'b0, "R1 valid reset", 256'(mac_valid), 256'd0);
    chk(blk_ready === 1'b0, "R1 ready reset", 256'(blk_ready), 256'd0);
    chk(eng_start === 1'b0, "R1 eng_start reset", 256'(eng_start), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      stub_dly = 1 + (v % 3);
      run_case(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
               int'(VEC[v][7:0]), v + 1, 0);
    end

    // R11: stray block while the inner key block is hashed
    stub_dly = 3;
    run_case(64, 0, 1, 0, 60, 2);
    // R9: start with reuse pulsed mid-run is ignored
    stub_dly = 2;
    run_case(17, 0, 2, 0, 61, 1);
    // R8: reuse after the short key just prepared
    run_case(0, 0, 1, 1, 62, 0);
    // R2: one-byte key
    run_case(1, 0, 1, 0, 63, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule